// File: doc/BRIEF.md
# Operand-Coherent Priority Bus Arbiter

This block decides which of four masters owns a shared system bus. The masters are an external bus requester, two DMA channels and a CPU. The bus is handed over only at an operand boundary. A multi-cycle operand, such as a 32-bit access split over four narrow-port cycles, is therefore never interrupted. A locked read-modify-write sequence is also never broken between its read and its write. Several operands in a row, such as the read and write halves of a dual-address DMA move or the words of a block register move, are separate operands, so ownership may change between them.

The granted master reports each bus cycle it completes on a shared status group. `cyc_done` marks the completing cycle. `cyc_last` says that the cycle closes an operand. `cyc_lock` says that the cycle belongs to a locked sequence that must continue. Both DMA request lines come from outside the clock domain. They pass through a two-stage synchronizer before they take part in arbitration. Each DMA channel has a programmable level that decides which of the two channels wins. Equal levels are flagged as a configuration error, and channel 1 is then preferred.

The controller has three states. IDLE means no grant. GRANT means an operand is in progress for the owner. LOCK means a locked sequence is in progress. The transitions are:
- IDLE→GRANT when any synchronized request is present.
- GRANT→LOCK on a completed cycle with `cyc_lock` set.
- GRANT→GRANT or LOCK→GRANT at an operand boundary (`cyc_done` and `cyc_last` with `cyc_lock` clear) when some request is present, with a fresh winner chosen.
- GRANT→IDLE or LOCK→IDLE at a boundary when no request is present.
- Every other cycle holds the state.

Top module: `bus_arbiter`

## Requirements
- R1: While `rst_n` is low, all four grants and `cfg_err` are 0.
- R2: At most one of `gnt_ext`, `gnt_dma1`, `gnt_dma2`, `gnt_cpu` is 1 in any cycle.
- R3: When the bus is idle or at an operand boundary and `ext_req` is 1, the next grant goes to the external requester.
- R4: With no external request, a synchronized DMA request beats `cpu_req`. When both DMA channels request, channel 2 wins only if `dma2_lvl` is numerically greater than `dma1_lvl`; otherwise channel 1 wins.
- R5: When `dma1_lvl` equals `dma2_lvl`, `cfg_err` is 1 one clock later and channel 1 is favoured. When the levels differ, `cfg_err` is 0 one clock later.
- R6: A grant holds, whatever the requests, through completed cycles with `cyc_last` at 0. It also holds through cycles with `cyc_done` at 0.
- R7: After a completed cycle with `cyc_lock` at 1, the grant holds until a completed cycle with `cyc_last` at 1 and `cyc_lock` at 0.
- R8: At every operand boundary the winner is chosen afresh from the current requests. A still-requesting owner keeps the bus only if it still wins.
- R9: A DMA request line that rises before clock edge n is first seen by arbitration at edge n+1. If the bus is idle, the grant appears after edge n+2 and not before.
- R10: From idle, a request is granted at the next edge. At a boundary with no request, all grants drop at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req | input | 1 | External bus request, synchronous |
| dma1_req_async | input | 1 | DMA channel 1 request, unsynchronized |
| dma2_req_async | input | 1 | DMA channel 2 request, unsynchronized |
| cpu_req | input | 1 | CPU bus request |
| dma1_lvl | input | LVL_W | Arbitration level of DMA channel 1 |
| dma2_lvl | input | LVL_W | Arbitration level of DMA channel 2 |
| cyc_done | input | 1 | Owner's bus cycle completes this clock |
| cyc_last | input | 1 | Completing cycle ends an operand |
| cyc_lock | input | 1 | Completing cycle is inside a locked sequence |
| gnt_ext | output | 1 | Bus granted to external requester |
| gnt_dma1 | output | 1 | Bus granted to DMA channel 1 |
| gnt_dma2 | output | 1 | Bus granted to DMA channel 2 |
| gnt_cpu | output | 1 | Bus granted to CPU |
| cfg_err | output | 1 | DMA levels are equal |

## Verification
The checker watches several rules on every clock:
- one-hot-or-none grants;
- grant stability inside an operand and after a locked cycle;
- external-first and DMA-over-CPU selection at each boundary;
- release to idle;
- the level-equality flag.

Only the bench scenarios can show the end-to-end sync latency of a raw DMA line. They also exercise every combination of requests and levels against an arithmetically computed winner, and the full multi-step hold sequences of a four-cycle operand and of a locked read followed by its write.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int NUM_MASTERS = 4;
    localparam int IDX_EXT  = 0;
    localparam int IDX_DMA1 = 1;
    localparam int IDX_DMA2 = 2;
    localparam int IDX_CPU  = 3;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_GRANT = 2'd1,
        ARB_LOCK  = 2'd2
    } arb_state_t;
endpackage

// File: rtl/arb_req_sync.sv
module arb_req_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req_async,
    output logic [WIDTH-1:0] req_sync
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic [STAGES-1:0] stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= {stage_q[STAGES-2:0], req_async[i]};
        end
        assign req_sync[i] = stage_q[STAGES-1];
    end
endmodule

// File: rtl/arb_prio.sv
module arb_prio
    import arb_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic                   ext_req,
    input  logic                   dma1_req,
    input  logic                   dma2_req,
    input  logic                   cpu_req,
    input  logic [LVL_W-1:0]       dma1_lvl,
    input  logic [LVL_W-1:0]       dma2_lvl,
    output logic [NUM_MASTERS-1:0] winner
);
    logic dma2_over_dma1;

    assign dma2_over_dma1 = dma2_lvl > dma1_lvl;

    always_comb begin
        winner = '0;
        if (ext_req)
            winner[IDX_EXT] = 1'b1;
        else if (dma1_req && dma2_req)
            winner[dma2_over_dma1 ? IDX_DMA2 : IDX_DMA1] = 1'b1;
        else if (dma1_req)
            winner[IDX_DMA1] = 1'b1;
        else if (dma2_req)
            winner[IDX_DMA2] = 1'b1;
        else if (cpu_req)
            winner[IDX_CPU] = 1'b1;
    end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] winner,
    input  logic                   cyc_done,
    input  logic                   cyc_last,
    input  logic                   cyc_lock,
    output logic [NUM_MASTERS-1:0] grant
);
    arb_state_t             state_q, state_d;
    logic [NUM_MASTERS-1:0] owner_q, owner_d;
    logic                   at_boundary;

    assign at_boundary = cyc_done && cyc_last && !cyc_lock;

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (|winner) begin
                    state_d = ARB_GRANT;
                    owner_d = winner;
                end
            end
            ARB_GRANT, ARB_LOCK: begin
                if (cyc_done && cyc_lock) begin
                    state_d = ARB_LOCK;
                end else if (at_boundary) begin
                    owner_d = winner;
                    state_d = (|winner) ? ARB_GRANT : ARB_IDLE;
                end
            end
            default: begin
                state_d = ARB_IDLE;
                owner_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        grant = (state_q == ARB_IDLE) ? '0 : owner_q;
    end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import arb_pkg::*;
#(
    parameter int LVL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_req,
    input  logic             dma1_req_async,
    input  logic             dma2_req_async,
    input  logic             cpu_req,
    input  logic [LVL_W-1:0] dma1_lvl,
    input  logic [LVL_W-1:0] dma2_lvl,
    input  logic             cyc_done,
    input  logic             cyc_last,
    input  logic             cyc_lock,
    output logic             gnt_ext,
    output logic             gnt_dma1,
    output logic             gnt_dma2,
    output logic             gnt_cpu,
    output logic             cfg_err
);
    localparam int NUM_DMA = 2;

    logic [NUM_DMA-1:0]     dma_sync;
    logic [NUM_MASTERS-1:0] winner;
    logic [NUM_MASTERS-1:0] grant;
    logic                   cfg_err_q;

    arb_req_sync #(.WIDTH(NUM_DMA), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async ({dma2_req_async, dma1_req_async}),
        .req_sync  (dma_sync)
    );

    arb_prio #(.LVL_W(LVL_W)) u_prio (
        .ext_req  (ext_req),
        .dma1_req (dma_sync[0]),
        .dma2_req (dma_sync[1]),
        .cpu_req  (cpu_req),
        .dma1_lvl (dma1_lvl),
        .dma2_lvl (dma2_lvl),
        .winner   (winner)
    );

    arb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .winner   (winner),
        .cyc_done (cyc_done),
        .cyc_last (cyc_last),
        .cyc_lock (cyc_lock),
        .grant    (grant)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_err_q <= 1'b0;
        else        cfg_err_q <= (dma1_lvl == dma2_lvl);
    end

    assign cfg_err  = cfg_err_q;
    assign gnt_ext  = grant[IDX_EXT];
    assign gnt_dma1 = grant[IDX_DMA1];
    assign gnt_dma2 = grant[IDX_DMA2];
    assign gnt_cpu  = grant[IDX_CPU];
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_req,
    input logic             cpu_req,
    input logic [1:0]       dma_sync,
    input logic [LVL_W-1:0] dma1_lvl,
    input logic [LVL_W-1:0] dma2_lvl,
    input logic             cyc_done,
    input logic             cyc_last,
    input logic             cyc_lock,
    input logic             gnt_ext,
    input logic             gnt_dma1,
    input logic             gnt_dma2,
    input logic             gnt_cpu,
    input logic             cfg_err
);
    logic [3:0] gv;
    logic       handover;

    assign gv       = {gnt_cpu, gnt_dma2, gnt_dma1, gnt_ext};
    assign handover = (gv == 4'b0) || (cyc_done && cyc_last && !cyc_lock);

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gv));

    assert_operand_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gv != 4'b0 && !(cyc_done && cyc_last && !cyc_lock)) |=> $stable(gv));

    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gv != 4'b0 && cyc_done && cyc_lock) |=> (gv == $past(gv)));

    assert_ext_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (handover && ext_req) |=> gnt_ext);

    assert_dma1_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (handover && !ext_req && dma_sync[0] && (!dma_sync[1] || dma1_lvl >= dma2_lvl))
        |=> gnt_dma1);

    assert_cpu_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (handover && !ext_req && dma_sync == 2'b00 && cpu_req) |=> gnt_cpu);

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (handover && !ext_req && dma_sync == 2'b00 && !cpu_req) |=> (gv == 4'b0));

    assert_cfg_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma1_lvl == dma2_lvl) |=> cfg_err);

    assert_cfg_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma1_lvl != dma2_lvl) |=> !cfg_err);
endmodule

bind bus_arbiter bus_arbiter_chk #(.LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_req  (ext_req),
    .cpu_req  (cpu_req),
    .dma_sync (dma_sync),
    .dma1_lvl (dma1_lvl),
    .dma2_lvl (dma2_lvl),
    .cyc_done (cyc_done),
    .cyc_last (cyc_last),
    .cyc_lock (cyc_lock),
    .gnt_ext  (gnt_ext),
    .gnt_dma1 (gnt_dma1),
    .gnt_dma2 (gnt_dma2),
    .gnt_cpu  (gnt_cpu),
    .cfg_err  (cfg_err)
);

// File: tb/bus_arbiter_bench.sv
module bus_arbiter_bench;
    localparam int  LW       = 2;
    localparam time CLK_HALF = 5ns;
    localparam int  WATCHDOG = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_req = 0, d1_raw = 0, d2_raw = 0, cpu_req = 0;
    logic [LW-1:0] lvl1 = '0, lvl2 = '0;
    logic          cyc_done = 0, cyc_last = 0, cyc_lock = 0;
    logic          gnt_ext, gnt_dma1, gnt_dma2, gnt_cpu, cfg_err;
    int            n_checks = 0;
    int            n_fails  = 0;
    bit            finished = 0;

    always #(CLK_HALF) clk = ~clk;

    bus_arbiter #(.LVL_W(LW)) u_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req),
        .dma1_req_async(d1_raw), .dma2_req_async(d2_raw), .cpu_req(cpu_req),
        .dma1_lvl(lvl1), .dma2_lvl(lvl2),
        .cyc_done(cyc_done), .cyc_last(cyc_last), .cyc_lock(cyc_lock),
        .gnt_ext(gnt_ext), .gnt_dma1(gnt_dma1), .gnt_dma2(gnt_dma2),
        .gnt_cpu(gnt_cpu), .cfg_err(cfg_err)
    );

    function automatic logic [3:0] gvec();
        return {gnt_cpu, gnt_dma2, gnt_dma1, gnt_ext};
    endfunction

    function automatic logic [3:0] model_win(logic e, logic a, logic b, logic c,
                                             logic [LW-1:0] la, logic [LW-1:0] lb);
        if (e)          return 4'b0001;
        if (a && b)     return (lb > la) ? 4'b0100 : 4'b0010;
        if (a)          return 4'b0010;
        if (b)          return 4'b0100;
        if (c)          return 4'b1000;
        return 4'b0000;
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic boundary(input logic last, input logic lock);
        cyc_done = 1; cyc_last = last; cyc_lock = lock;
        edges(1);
        cyc_done = 0; cyc_last = 0; cyc_lock = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset holds everything low even with equal levels and requests
        lvl1 = 2'd1; lvl2 = 2'd1; cpu_req = 1;
        edges(3);
        check(gvec(), 4'b0000, "R1 grants in reset");
        check({3'b0, cfg_err}, 4'b0000, "R1 cfg_err in reset");
        cpu_req = 0;
        rst_n = 1;
        edges(1);
        // R5: equal levels flagged one clock later
        check({3'b0, cfg_err}, 4'b0001, "R5 cfg_err equal levels");
        lvl2 = 2'd3;
        edges(1);
        check({3'b0, cfg_err}, 4'b0000, "R5 cfg_err distinct levels");

        // R10: idle request granted at next edge
        cpu_req = 1;
        edges(1);
        check(gvec(), 4'b1000, "R10 idle grant to cpu");

        // R6: four-cycle operand not split by higher request
        ext_req = 1;
        for (int k = 0; k < 3; k++) begin
            boundary(0, 0);
            check(gvec(), 4'b1000, "R6 hold within operand");
        end
        edges(2);
        check(gvec(), 4'b1000, "R6 hold while no cycle completes");
        boundary(1, 0);
        check(gvec(), 4'b0001, "R6 handover after last cycle");

        // R7: locked read-modify-write kept together
        boundary(1, 0);
        ext_req = 0;
        boundary(1, 0);
        check(gvec(), 4'b1000, "R8 cpu regains bus");
        ext_req = 1;
        boundary(1, 1);
        check(gvec(), 4'b1000, "R7 hold after locked read");
        boundary(0, 0);
        check(gvec(), 4'b1000, "R7 hold during locked write");
        boundary(1, 0);
        check(gvec(), 4'b0001, "R7 release after locked write");
        ext_req = 0;

        // R8: back-to-back operands re-arbitrate; owner keeps while it wins
        boundary(1, 0);
        check(gvec(), 4'b1000, "R8 cpu after ext drops");
        boundary(1, 0);
        check(gvec(), 4'b1000, "R8 cpu keeps across operands");
        cpu_req = 0;
        boundary(1, 0);
        check(gvec(), 4'b0000, "R10 release to idle");

        // R9: raw DMA line latency from idle
        d1_raw = 1;
        edges(1);
        check(gvec(), 4'b0000, "R9 no grant after first edge");
        edges(1);
        check(gvec(), 4'b0000, "R9 no grant after second edge");
        edges(1);
        check(gvec(), 4'b0010, "R9 grant after third edge");
        d1_raw = 0;
        edges(3);
        boundary(1, 0);
        check(gvec(), 4'b0000, "R10 dma release");

        // Sweep: every request pattern against every level pair
        for (int la = 0; la < (1 << LW); la++) begin
            for (int lb = 0; lb < (1 << LW); lb++) begin
                for (int p = 0; p < 16; p++) begin
                    logic [3:0] exp;
                    string      tag;
                    lvl1 = la[LW-1:0]; lvl2 = lb[LW-1:0];
                    ext_req = p[0]; d1_raw = p[1]; d2_raw = p[2]; cpu_req = p[3];
                    exp = model_win(p[0], p[1], p[2], p[3], la[LW-1:0], lb[LW-1:0]);
                    if (p[0])                  tag = "R3 sweep";
                    else if (p[1] && p[2] && la == lb) tag = "R5 sweep tie";
                    else if (p[3:1] != 3'b000) tag = "R4 sweep";
                    else                       tag = "R10 sweep none";
                    edges(3);
                    boundary(1, 0);
                    check(gvec(), exp, tag);
                    ext_req = 0; d1_raw = 0; d2_raw = 0; cpu_req = 0;
                    edges(3);
                    boundary(1, 0);
                    check(gvec(), 4'b0000, "R10 sweep release");
                end
            end
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule